// File: doc/BRIEF.md
# Multi-Block Erase Scheduler

This block sequences the erasure of a set of equal-sized array blocks (eight by default). Block-erase confirm commands each name one block by index and are gathered into a pending mask while a gathering window is open. Every confirm restarts the window's timeout. When the window runs out with no new confirm, the scheduler works through the selected blocks from the lowest index to the highest. Each block gets a zero-fill phase and then an erase pass of fixed length, followed by a verify step.

Blocks flagged in the protection mask are removed from the set at the moment the erase starts. A whole-array erase command selects every unprotected block and starts at once, with no window. An erase that was started from a confirm can be suspended and resumed, and a suspend issued during the window also closes the window. A reset command abandons the operation.

The cell timing is modelled as parameterised clock-cycle counts, so a simulation can use short values. A test input forces verify failures. After a bounded number of failed passes on one block, the scheduler raises an error.

Top module: `mbe_sched`

## Requirements
- R1: After reset, busy, win_open, suspended, zero_fill, done and error are all low and blk_mask is zero.
- R2: Commands arrive as a one-cycle cmd_vld with a 3-bit cmd_op: 0 is a block confirm (or a resume), 1 is a whole-array erase, 2 is a suspend, 3 is a reset, and 4 to 7 are any other command. A confirm from idle opens the window and sets the bit for cmd_blk in blk_mask. Each further confirm in the window adds its bit and restarts the timeout. The erase starts at the WIN_CYC-th clock edge after the last confirm.
- R3: Each selected block gets FILL_CYC cycles with zero_fill high and then ERASE_CYC cycles of erase. Blocks are taken in ascending index order, and cur_blk names the block being worked on. The block's blk_mask bit clears when its pass verifies. done rises once blk_mask becomes zero, WIN_CYC + n*(FILL_CYC+ERASE_CYC) edges after the last confirm for n blocks.
- R4: Blocks whose prot_mask bit is set when the erase starts are dropped from blk_mask and take no time. If every selected block is protected, done rises at the window expiry with blk_mask zero.
- R5: A reset, a whole-array erase or any other command while the window is open aborts the operation. From the next cycle busy and win_open are low, blk_mask is zero, and done stays low.
- R6: A suspend while the window is open closes it. From the next cycle suspended is high and busy is low. The confirm that resumes starts the erase on that same edge.
- R7: A suspend during zero-fill or erase of a confirm-started operation sets suspended and clears busy from the next cycle. Progress and blk_mask are then frozen. The completion time grows by the gap between the suspend edge and the resume edge plus one cycle.
- R8: While suspended, only a confirm (resume) or a reset has any effect. A reset clears suspended and blk_mask and leaves done low.
- R9: A whole-array erase from idle selects all unprotected blocks at once, with no window. Suspend commands are ignored while it runs.
- R10: During zero-fill and erase, confirms and other commands are ignored. blk_mask and the completion time are unchanged.
- R11: If force_fail is high at the end of an erase pass, the pass is repeated. After VERIFY_MAX failed passes on one block, error rises, busy drops and done stays low. A reset command clears error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_blk | input | BLK_W | Block index carried by a confirm |
| prot_mask | input | N_BLK | Per-block protection flags |
| force_fail | input | 1 | Test input: the verify at the end of a pass fails |
| busy | output | 1 | Window open, zero-fill or erase in progress |
| win_open | output | 1 | Gathering window open |
| suspended | output | 1 | Operation suspended |
| zero_fill | output | 1 | Current block in its zero-fill phase |
| done | output | 1 | Last operation completed; held until the next command |
| error | output | 1 | Verify retry limit exceeded |
| blk_mask | output | N_BLK | Blocks selected and not yet erased |
| cur_blk | output | BLK_W | Lowest pending block, the one being worked on |

## Verification
The assertions check, on every cycle, the effects of one event on the next cycle. A suspend in the window leads to the suspended state with busy low. Another command in the window clears the whole operation. A suspended scheduler with no command keeps its mask. No mask bit appears outside the window. done rises only with an empty mask. error rises only after a forced verify failure. zero-fill is followed by busy unless a command arrives. The exact cycle counts of the window, the fill and erase phases, the retry and the suspension gap, as well as the processing order and the exclusion of protected blocks, can only be shown by the bench's scenarios. These scenarios compare edge numbers against values computed from the parameters.

// File: rtl/mbe_pkg.sv
package mbe_pkg;
  typedef enum logic [2:0] {
    OP_CONF  = 3'd0,
    OP_CHIP  = 3'd1,
    OP_SUSP  = 3'd2,
    OP_RST   = 3'd3,
    OP_OTHER = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WIN   = 3'd1,
    ST_FILL  = 3'd2,
    ST_ERASE = 3'd3,
    ST_SUSP  = 3'd4
  } st_e;
endpackage

// File: rtl/mbe_cmd_dec.sv
module mbe_cmd_dec (
  input  logic       cmd_vld,
  input  logic [2:0] cmd_op,
  output logic       evt_conf,
  output logic       evt_chip,
  output logic       evt_susp,
  output logic       evt_rst,
  output logic       evt_other
);
  import mbe_pkg::*;

  always_comb begin
    evt_conf  = 1'b0;
    evt_chip  = 1'b0;
    evt_susp  = 1'b0;
    evt_rst   = 1'b0;
    evt_other = 1'b0;
    if (cmd_vld) begin
      case (cmd_op)
        OP_CONF: evt_conf  = 1'b1;
        OP_CHIP: evt_chip  = 1'b1;
        OP_SUSP: evt_susp  = 1'b1;
        OP_RST:  evt_rst   = 1'b1;
        default: evt_other = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/mbe_tmr.sv
module mbe_tmr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/mbe_pick.sv
module mbe_pick #(
  parameter int N_BLK = 8,
  localparam int BLK_W = $clog2(N_BLK)
) (
  input  logic [N_BLK-1:0] mask,
  output logic [BLK_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N_BLK - 1; i >= 0; i--) begin
      if (mask[i]) idx = BLK_W'(i);
    end
  end
endmodule

// File: rtl/mbe_sched.sv
module mbe_sched #(
  parameter int N_BLK      = 8,
  parameter int WIN_CYC    = 16,
  parameter int FILL_CYC   = 3,
  parameter int ERASE_CYC  = 5,
  parameter int VERIFY_MAX = 3,
  localparam int BLK_W = $clog2(N_BLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic [2:0]       cmd_op,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic [N_BLK-1:0] prot_mask,
  input  logic             force_fail,
  output logic             busy,
  output logic             win_open,
  output logic             suspended,
  output logic             zero_fill,
  output logic             done,
  output logic             error,
  output logic [N_BLK-1:0] blk_mask,
  output logic [BLK_W-1:0] cur_blk
);
  import mbe_pkg::*;

  localparam int MAX_A  = (WIN_CYC > FILL_CYC) ? WIN_CYC : FILL_CYC;
  localparam int MAX_C  = (MAX_A > ERASE_CYC) ? MAX_A : ERASE_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam int PASS_W = $clog2(VERIFY_MAX + 1);
  localparam logic [CNT_W-1:0]  WIN_LD   = CNT_W'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0]  FILL_LD  = CNT_W'(FILL_CYC - 1);
  localparam logic [CNT_W-1:0]  ERASE_LD = CNT_W'(ERASE_CYC - 1);
  localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(VERIFY_MAX - 1);

  function automatic logic [N_BLK-1:0] blk_bit(input logic [BLK_W-1:0] i);
    blk_bit = {{(N_BLK-1){1'b0}}, 1'b1} << i;
  endfunction

  function automatic logic [N_BLK-1:0] keep_open(input logic [N_BLK-1:0] m,
                                                 input logic [N_BLK-1:0] p);
    keep_open = m & ~p;
  endfunction

  // decoded command events
  logic evt_conf, evt_chip, evt_susp, evt_rst, evt_other;

  mbe_cmd_dec dec_i (
    .cmd_vld  (cmd_vld),
    .cmd_op   (cmd_op),
    .evt_conf (evt_conf),
    .evt_chip (evt_chip),
    .evt_susp (evt_susp),
    .evt_rst  (evt_rst),
    .evt_other(evt_other)
  );

  // state
  st_e               st_q, st_d, res_q, res_d;
  logic [N_BLK-1:0]  mask_q, mask_d;
  logic [PASS_W-1:0] pass_q, pass_d;
  logic              chip_q, chip_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  // timer control and named internal events
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             evt_start;
  logic             evt_blk_done;
  logic [N_BLK-1:0] start_src;
  logic [N_BLK-1:0] start_eff;
  logic [N_BLK-1:0] rem_mask;
  logic [BLK_W-1:0] pick_idx;

  mbe_tmr #(.CNT_W(CNT_W)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .dec     (tmr_dec),
    .zero    (tmr_zero)
  );

  mbe_pick #(.N_BLK(N_BLK)) pick_i (
    .mask(mask_q),
    .idx (pick_idx)
  );

  always_comb begin
    st_d         = st_q;
    res_d        = res_q;
    mask_d       = mask_q;
    pass_d       = pass_q;
    chip_d       = chip_q;
    done_d       = done_q;
    err_d        = err_q;
    tmr_load     = 1'b0;
    tmr_val      = WIN_LD;
    tmr_dec      = 1'b0;
    evt_start    = 1'b0;
    evt_blk_done = 1'b0;
    start_src    = mask_q;
    rem_mask     = mask_q & ~blk_bit(pick_idx);

    unique case (st_q)
      ST_IDLE: begin
        if (evt_conf) begin
          st_d     = ST_WIN;
          mask_d   = blk_bit(cmd_blk);
          chip_d   = 1'b0;
          done_d   = 1'b0;
          err_d    = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = WIN_LD;
        end else if (evt_chip) begin
          chip_d    = 1'b1;
          done_d    = 1'b0;
          err_d     = 1'b0;
          evt_start = 1'b1;
          start_src = '1;
        end else if (evt_rst) begin
          done_d = 1'b0;
          err_d  = 1'b0;
        end
      end
      ST_WIN: begin
        if (evt_conf) begin
          mask_d   = mask_q | blk_bit(cmd_blk);
          tmr_load = 1'b1;
          tmr_val  = WIN_LD;
        end else if (evt_susp) begin
          st_d  = ST_SUSP;
          res_d = ST_WIN;
        end else if (evt_rst || evt_other || evt_chip) begin
          st_d   = ST_IDLE;
          mask_d = '0;
        end else if (tmr_zero) begin
          evt_start = 1'b1;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_FILL: begin
        if (evt_rst) begin
          st_d   = ST_IDLE;
          mask_d = '0;
        end else if (evt_susp && !chip_q) begin
          st_d  = ST_SUSP;
          res_d = ST_FILL;
        end else if (tmr_zero) begin
          st_d     = ST_ERASE;
          tmr_load = 1'b1;
          tmr_val  = ERASE_LD;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_ERASE: begin
        if (evt_rst) begin
          st_d   = ST_IDLE;
          mask_d = '0;
        end else if (evt_susp && !chip_q) begin
          st_d  = ST_SUSP;
          res_d = ST_ERASE;
        end else if (tmr_zero) begin
          if (force_fail) begin
            if (pass_q == PASS_LAST) begin
              st_d   = ST_IDLE;
              mask_d = '0;
              err_d  = 1'b1;
            end else begin
              pass_d   = pass_q + 1'b1;
              tmr_load = 1'b1;
              tmr_val  = ERASE_LD;
            end
          end else begin
            evt_blk_done = 1'b1;
            mask_d       = rem_mask;
            pass_d       = '0;
            if (rem_mask == '0) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else begin
              st_d     = ST_FILL;
              tmr_load = 1'b1;
              tmr_val  = FILL_LD;
            end
          end
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_SUSP: begin
        if (evt_rst) begin
          st_d   = ST_IDLE;
          mask_d = '0;
        end else if (evt_conf) begin
          if (res_q == ST_WIN) evt_start = 1'b1;
          else                 st_d = res_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    start_eff = keep_open(start_src, prot_mask);
    if (evt_start) begin
      if (start_eff == '0) begin
        st_d   = ST_IDLE;
        mask_d = '0;
        done_d = 1'b1;
      end else begin
        st_d     = ST_FILL;
        mask_d   = start_eff;
        pass_d   = '0;
        tmr_load = 1'b1;
        tmr_val  = FILL_LD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      res_q  <= ST_IDLE;
      mask_q <= '0;
      pass_q <= '0;
      chip_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      res_q  <= res_d;
      mask_q <= mask_d;
      pass_q <= pass_d;
      chip_q <= chip_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign busy      = (st_q == ST_WIN) || (st_q == ST_FILL) || (st_q == ST_ERASE);
  assign win_open  = (st_q == ST_WIN);
  assign suspended = (st_q == ST_SUSP);
  assign zero_fill = (st_q == ST_FILL);
  assign done      = done_q;
  assign error     = err_q;
  assign blk_mask  = mask_q;
  assign cur_blk   = pick_idx;
endmodule

// File: rtl/mbe_sched_chk.sv
module mbe_sched_chk #(
  parameter int N_BLK = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_vld,
  input logic [2:0]       cmd_op,
  input logic             force_fail,
  input logic             busy,
  input logic             win_open,
  input logic             suspended,
  input logic             zero_fill,
  input logic             done,
  input logic             error,
  input logic [N_BLK-1:0] blk_mask
);
  // R6
  susp_closes_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 3'd2 && win_open) |=> (suspended && !busy && !win_open));

  // R5
  window_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op >= 3'd4 && win_open) |=> (!busy && !win_open && blk_mask == '0));

  // R8
  suspend_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !cmd_vld) |=> (suspended && $stable(blk_mask)));

  // R10
  no_new_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !win_open) |=> ((blk_mask & ~$past(blk_mask)) == '0));

  // R3
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (blk_mask == '0));

  // R11
  error_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(force_fail));

  // R3
  fill_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_fill && !cmd_vld) |=> busy);
endmodule

bind mbe_sched mbe_sched_chk #(.N_BLK(N_BLK)) chk_i (.*);

// File: tb/mbe_sched_tb.sv
`timescale 1ns/1ps
module mbe_sched_tb_top;
  localparam int N  = 8;
  localparam int BW = 3;
  localparam int W  = 6;
  localparam int F  = 2;
  localparam int X  = 3;
  localparam int VM = 2;
  localparam int BLK = F + X;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_vld = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [BW-1:0] cmd_blk = '0;
  logic [N-1:0]  prot_mask = '0;
  logic          force_fail = 1'b0;
  logic          busy, win_open, suspended, zero_fill, done, error;
  logic [N-1:0]  blk_mask;
  logic [BW-1:0] cur_blk;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mbe_sched #(.N_BLK(N), .WIN_CYC(W), .FILL_CYC(F), .ERASE_CYC(X), .VERIFY_MAX(VM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .prot_mask(prot_mask), .force_fail(force_fail), .busy(busy), .win_open(win_open),
    .suspended(suspended), .zero_fill(zero_fill), .done(done), .error(error),
    .blk_mask(blk_mask), .cur_blk(cur_blk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // called at a negedge; the command is taken at the next edge, whose number is returned
  task automatic send(input logic [2:0] op, input logic [BW-1:0] b, output int c);
    cmd_vld = 1'b1; cmd_op = op; cmd_blk = b;
    @(posedge clk); #1 c = cyc;
    @(negedge clk);
    cmd_vld = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // done low after edge t-1, high after edge t
  task automatic expect_done_at(input string req, input int t);
    wait_until(t - 1);
    chk_eq(req, done, 0);
    wait_until(t);
    chk_eq(req, done, 1);
    chk_eq(req, blk_mask, 0);
  endtask

  task automatic t_reset();
    chk_eq("R1 busy", busy, 0);
    chk_eq("R1 win", win_open, 0);
    chk_eq("R1 susp", suspended, 0);
    chk_eq("R1 fill", zero_fill, 0);
    chk_eq("R1 done", done, 0);
    chk_eq("R1 err", error, 0);
    chk_eq("R1 mask", blk_mask, 0);
  endtask

  task automatic t_single();
    int c0, dummy;
    send(3'd0, 3'd2, c0);
    chk_eq("R2 win", win_open, 1);
    chk_eq("R2 mask", blk_mask, 8'h04);
    wait_until(c0 + W - 1);
    chk_eq("R2 still open", win_open, 1);
    wait_until(c0 + W);
    chk_eq("R3 fill", zero_fill, 1);
    chk_eq("R3 cur", cur_blk, 2);
    wait_until(c0 + W + F);
    chk_eq("R3 erase busy", busy, 1);
    chk_eq("R3 fill over", zero_fill, 0);
    expect_done_at("R3 single", c0 + W + BLK);
    dummy = 0;
  endtask

  task automatic t_multi();
    int c0, c1;
    send(3'd0, 3'd5, c0);
    wait_until(c0 + 2);
    send(3'd0, 3'd1, c1);
    chk_eq("R2 restart", c1, c0 + 3);
    wait_until(c1 + W - 1);
    chk_eq("R2 restarted win", win_open, 1);
    wait_until(c1 + W);
    chk_eq("R3 order first", cur_blk, 1);
    chk_eq("R2 mask2", blk_mask, 8'h22);
    wait_until(c1 + W + BLK);
    chk_eq("R3 order second", cur_blk, 5);
    chk_eq("R3 mask after first", blk_mask, 8'h20);
    expect_done_at("R3 multi", c1 + W + 2 * BLK);
  endtask

  task automatic t_prot();
    int c0, c1;
    prot_mask = 8'h04;
    send(3'd0, 3'd2, c0);
    send(3'd0, 3'd6, c1);
    wait_until(c1 + W);
    chk_eq("R4 drop protected", blk_mask, 8'h40);
    expect_done_at("R4 partial", c1 + W + BLK);
    send(3'd0, 3'd2, c0);
    expect_done_at("R4 all protected", c0 + W);
    prot_mask = '0;
  endtask

  task automatic t_abort();
    int c0, c1;
    send(3'd0, 3'd3, c0);
    send(3'd5, 3'd0, c1);
    chk_eq("R5 other busy", busy, 0);
    chk_eq("R5 other mask", blk_mask, 0);
    chk_eq("R5 other win", win_open, 0);
    send(3'd0, 3'd4, c0);
    send(3'd3, 3'd0, c1);
    chk_eq("R5 reset busy", busy, 0);
    chk_eq("R5 reset mask", blk_mask, 0);
    send(3'd0, 3'd4, c0);
    send(3'd1, 3'd0, c1);
    chk_eq("R5 chip busy", busy, 0);
    wait_until(c1 + W + 2 * BLK);
    chk_eq("R5 no done", done, 0);
  endtask

  task automatic t_susp_win();
    int c0, cs, cr, cx;
    send(3'd0, 3'd4, c0);
    wait_until(c0 + 2);
    send(3'd2, 3'd0, cs);
    chk_eq("R6 susp", suspended, 1);
    chk_eq("R6 busy", busy, 0);
    chk_eq("R6 win closed", win_open, 0);
    wait_until(cs + W + 3);
    chk_eq("R6 held", suspended, 1);
    send(3'd4, 3'd0, cx);
    chk_eq("R8 other ignored", suspended, 1);
    send(3'd1, 3'd0, cx);
    chk_eq("R8 chip ignored", suspended, 1);
    chk_eq("R8 mask kept", blk_mask, 8'h10);
    send(3'd0, 3'd0, cr);
    chk_eq("R6 resume fill", zero_fill, 1);
    chk_eq("R6 resume mask", blk_mask, 8'h10);
    expect_done_at("R6 resume", cr + BLK);
  endtask

  task automatic t_susp_erase();
    int c0, cs, cr;
    send(3'd0, 3'd0, c0);
    wait_until(c0 + W + 1);
    send(3'd2, 3'd0, cs);
    chk_eq("R7 susp", suspended, 1);
    chk_eq("R7 busy", busy, 0);
    wait_until(cs + 3);
    chk_eq("R7 frozen", blk_mask, 8'h01);
    chk_eq("R7 no done", done, 0);
    send(3'd0, 3'd0, cr);
    chk_eq("R7 resumed", busy, 1);
    expect_done_at("R7 extended", c0 + W + BLK + (cr - cs + 1));
  endtask

  task automatic t_susp_reset();
    int c0, cs, cr;
    send(3'd0, 3'd7, c0);
    wait_until(c0 + W + 3);
    send(3'd2, 3'd0, cs);
    chk_eq("R8 susp", suspended, 1);
    send(3'd3, 3'd0, cr);
    chk_eq("R8 reset susp", suspended, 0);
    chk_eq("R8 reset mask", blk_mask, 0);
    chk_eq("R8 reset busy", busy, 0);
    wait_until(cr + 2 * BLK);
    chk_eq("R8 reset done", done, 0);
  endtask

  task automatic t_chip();
    int c0, cs;
    prot_mask = 8'h81;
    send(3'd1, 3'd0, c0);
    chk_eq("R9 no window", win_open, 0);
    chk_eq("R9 fill", zero_fill, 1);
    chk_eq("R9 mask", blk_mask, 8'h7E);
    wait_until(c0 + 2);
    send(3'd2, 3'd0, cs);
    chk_eq("R9 susp ignored", suspended, 0);
    chk_eq("R9 still busy", busy, 1);
    expect_done_at("R9 chip", c0 + 6 * BLK);
    prot_mask = '0;
  endtask

  task automatic t_ignore();
    int c0, cx;
    send(3'd0, 3'd3, c0);
    wait_until(c0 + W + 1);
    send(3'd0, 3'd5, cx);
    chk_eq("R10 confirm ignored", blk_mask, 8'h08);
    send(3'd6, 3'd0, cx);
    chk_eq("R10 other ignored", busy, 1);
    expect_done_at("R10 timing", c0 + W + BLK);
  endtask

  task automatic t_fail();
    int c0, cr;
    force_fail = 1'b1;
    send(3'd0, 3'd1, c0);
    wait_until(c0 + W + F + X);
    force_fail = 1'b0;
    chk_eq("R11 retry busy", busy, 1);
    expect_done_at("R11 retry", c0 + W + F + 2 * X);
    chk_eq("R11 retry no err", error, 0);
    force_fail = 1'b1;
    send(3'd0, 3'd1, c0);
    wait_until(c0 + W + F + VM * X - 1);
    chk_eq("R11 err early", error, 0);
    wait_until(c0 + W + F + VM * X);
    chk_eq("R11 err", error, 1);
    chk_eq("R11 busy", busy, 0);
    chk_eq("R11 done", done, 0);
    force_fail = 1'b0;
    send(3'd3, 3'd0, cr);
    chk_eq("R11 cleared", error, 0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc >= 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_prot();
    t_abort();
    t_susp_win();
    t_susp_erase();
    t_susp_reset();
    t_chip();
    t_ignore();
    t_fail();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule